// File: doc/BRIEF.md
# Real-Time Clock Interrupt, Status and Watchdog Controller

This block sits beside the timekeeping counters of a serial real-time clock. It holds the interrupt control byte written by the host and the status byte the host reads back. It turns alarm matches, power-fail events and periodic ticks into a single active-low interrupt line. A chip-enable watchdog resets the host processor if the host stops servicing it. The power-down state drives the supply-enable, clock-out gate, serial-enable and CPU-reset outputs low, and any interrupt brings them back.

The interrupt line stays asserted until the host reads the status byte. That read clears every flag except power-sense, which is held until power sensing is disabled. Periodic interrupts come from rising edges of a prescaler tap bus, or from the minute, hour and day carry pulses of the calendar. The watchdog counts a slow tick. It is serviced only by a chip-enable pulse that carries no serial transfer.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00 and the status byte reads 0x10 (bit 4 first-time-up set). `int_n`, `pse`, `clkout_en`, `serial_en` and `cpur_n` are all high.
- R2: A status read (`stat_rd` high for one cycle) clears every status bit except bit 2 (power-sense). A flag whose event arrives in the same cycle as the read is still set afterwards.
- R3: Control bits 3..0 select the periodic source. Code 0 selects nothing. Codes 1..12 select `taps[code-1]`, where `taps[i]` toggles at 2048/2^i Hz. Codes 13, 14 and 15 select the minute, hour and day carries. A rising edge of the selected tap, or a carry pulse, sets status bits 0 and 3. Unselected sources change nothing.
- R4: `int_n` is low exactly while status bit 3 (interrupt true) is set. Bit 3 is set by an enabled alarm, periodic or power-sense event, and is cleared only by a status read.
- R5: With control bit 4 set, an `alarm_match` pulse sets status bits 1 and 3 on the first later cycle in which `osc_tick` is high, and not before. With bit 4 clear, a match has no effect.
- R6: With control bit 5 set after a 0-to-1 write, a `pwr_fail` pulse sets status bits 2 and 3 and disarms the sense. Further failures are ignored until bit 5 is written 0 and then 1. Writing bit 5 as 0 clears status bit 2.
- R7: With control bit 7 set, `WD_LIMIT` (default 2) `wd_tick` pulses without a service set status bit 6 and drive `cpur_n` low for `CPUR_PULSE` (default 4) cycles. A falling edge of `ce` while `ce_xfer` is low services the watchdog and restarts its count.
- R8: A chip-enable cycle with `ce_xfer` high does not service the watchdog.
- R9: While control bit 6 (power-down) is set, `pse`, `clkout_en`, `serial_en` and `cpur_n` are low, and writes to the control byte are ignored.
- R10: Any event that sets status bit 3 during power-down clears control bit 6. The outputs come back high in the same cycle that the flag becomes visible.
- R11: Status bits 7 and 5 always read 0. Bit 4 is set only by reset and is cleared by the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| icr_we | input | 1 | Control byte write strobe |
| icr_wdata | input | 8 | Control byte write data |
| stat_rd | input | 1 | Status read strobe; clears flags |
| alarm_match | input | 1 | Alarm comparator match pulse |
| osc_tick | input | 1 | One pulse per 32 kHz oscillator period |
| pwr_fail | input | 1 | Power-fail event pulse |
| taps | input | 12 | Prescaler tap levels, bit i at 2048/2^i Hz |
| min_carry | input | 1 | Minute rollover pulse |
| hour_carry | input | 1 | Hour rollover pulse |
| day_carry | input | 1 | Day rollover pulse |
| ce | input | 1 | Chip-enable level |
| ce_xfer | input | 1 | Current CE cycle carried a serial transfer |
| wd_tick | input | 1 | Watchdog time-base tick |
| int_n | output | 1 | Active-low interrupt (open-drain pull-down control) |
| cpur_n | output | 1 | Active-low CPU reset |
| pse | output | 1 | Supply enable |
| clkout_en | output | 1 | Clock-out gate |
| serial_en | output | 1 | Serial interface enable |
| icr_o | output | 8 | Control byte readback |
| status_o | output | 8 | Status byte readback |

## Verification
Some properties are checked on every cycle. The interrupt line never releases without a status read. The power-sense flag survives a read. First-time-up cannot return. A watchdog fire always comes with a low CPU reset. Power-down forces the outputs low and holds the control byte against writes. Other behaviours need the bench's scenarios. These are the periodic select-to-source mapping, swept over every code and every source. They also include the alarm delay to the oscillator tick, the power-sense re-arm sequence, the watchdog service rules with and without a transfer, the read/event collision, and the exit from power-down on an interrupt.

// File: rtl/rtc_irq_pkg.sv
// Package: shared bit positions for the control and status bytes.
// Assumes an 8-bit control byte and an 8-bit status byte.
package rtc_irq_pkg;
    localparam int SEL_W   = 4;
    // control byte
    localparam int C_WDOG  = 7;
    localparam int C_PDOWN = 6;
    localparam int C_PSEN  = 5;
    localparam int C_ALEN  = 4;
    // status byte
    localparam int S_WDOG  = 6;
    localparam int S_FTU   = 4;
    localparam int S_IRQ   = 3;
    localparam int S_PS    = 2;
    localparam int S_ALM   = 1;
    localparam int S_PER   = 0;
endpackage

// File: rtl/rtc_periodic_sel.sv
// Periodic source selector: detects rising edges on the prescaler taps and
// picks one edge or carry pulse by the select code.
// Assumes the taps are synchronous to clk and NUM_TAPS + 4 <= 2**SEL_W.
module rtc_periodic_sel #(
    parameter int NUM_TAPS = 12,
    parameter int SEL_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                min_carry,
    input  logic                hour_carry,
    input  logic                day_carry,
    output logic                evt
);
    localparam int NSRC = 2 ** SEL_W;

    logic [NUM_TAPS-1:0] prev_q;
    logic [NUM_TAPS-1:0] rise;
    logic [NSRC-1:0]     src;

    // remember the last tap levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= taps;
    end

    assign rise = taps & ~prev_q;

    // build the source vector indexed by select code; code 0 stays idle
    always_comb begin
        src = '0;
        for (int k = 0; k < NUM_TAPS; k++) src[k+1] = rise[k];
        src[NUM_TAPS+1] = min_carry;
        src[NUM_TAPS+2] = hour_carry;
        src[NUM_TAPS+3] = day_carry;
    end

    assign evt = src[sel];
endmodule

// File: rtl/rtc_wdog.sv
// Chip-enable watchdog: counts time-base ticks since the last transfer-free
// CE pulse and issues a CPU reset pulse when the limit is reached.
// Assumes ce and ce_xfer are synchronous to clk; ce_xfer is valid at CE fall.
module rtc_wdog #(
    parameter int WD_LIMIT   = 2,
    parameter int CPUR_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ce,
    input  logic ce_xfer,
    input  logic wd_tick,
    output logic fire,
    output logic rst_active
);
    localparam int CW = $clog2(WD_LIMIT + 1);
    localparam int PW = $clog2(CPUR_PULSE + 1);

    logic          ce_q;
    logic          service;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] pcnt_q;

    // track CE for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ce_q <= 1'b0;
        else        ce_q <= ce;
    end

    assign service = ce_q & ~ce & ~ce_xfer;
    assign fire    = en & wd_tick & ~service & (cnt_q == CW'(WD_LIMIT - 1));

    // tick counter, restarted on service, fire or disable
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (!en || service || fire) cnt_q <= '0;
        else if (wd_tick)              cnt_q <= cnt_q + 1'b1;
    end

    // stretch the fire event into a reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n)            pcnt_q <= '0;
        else if (fire)         pcnt_q <= PW'(CPUR_PULSE);
        else if (pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
    end

    assign rst_active = (pcnt_q != '0);
endmodule

// File: rtl/rtc_irq_status.sv
// Status byte: sets flags from events, delays the alarm to the oscillator
// tick, and clears flags on read except power-sense.
// Assumes event inputs are already gated by their enables.
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alm_evt,
    input  logic       osc_tick,
    input  logic       ps_evt,
    input  logic       per_evt,
    input  logic       wd_fire,
    input  logic       ps_clr,
    input  logic       stat_rd,
    output logic [7:0] status,
    output logic       irq_set
);
    logic       alm_pend_q;
    logic       alm_set;
    logic [7:0] st_q;
    logic [7:0] st_d;

    assign alm_set = alm_pend_q & osc_tick;
    assign irq_set = alm_set | ps_evt | per_evt;

    // hold a match until the next oscillator tick
    always_ff @(posedge clk) begin
        if (!rst_n) alm_pend_q <= 1'b0;
        else        alm_pend_q <= alm_evt | (alm_pend_q & ~osc_tick);
    end

    // next status: read-clear first, then new events on top
    always_comb begin
        st_d = stat_rd ? (st_q & (8'd1 << S_PS)) : st_q;
        if (wd_fire) st_d[S_WDOG] = 1'b1;
        if (irq_set) st_d[S_IRQ]  = 1'b1;
        if (ps_clr)  st_d[S_PS]   = 1'b0;
        if (ps_evt)  st_d[S_PS]   = 1'b1;
        if (alm_set) st_d[S_ALM]  = 1'b1;
        if (per_evt) st_d[S_PER]  = 1'b1;
    end

    // status register, first-time-up on reset
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= 8'd1 << S_FTU;
        else        st_q <= st_d;
    end

    assign status = st_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Top: interrupt control byte, power-sense arming, power-down output gating,
// and the interrupt line. Writes are ignored while power-down is active.
// Assumes all inputs are synchronous to clk.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int NUM_TAPS   = 12,
    parameter int WD_LIMIT   = 2,
    parameter int CPUR_PULSE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                icr_we,
    input  logic [7:0]          icr_wdata,
    input  logic                stat_rd,
    input  logic                alarm_match,
    input  logic                osc_tick,
    input  logic                pwr_fail,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                min_carry,
    input  logic                hour_carry,
    input  logic                day_carry,
    input  logic                ce,
    input  logic                ce_xfer,
    input  logic                wd_tick,
    output logic                int_n,
    output logic                cpur_n,
    output logic                pse,
    output logic                clkout_en,
    output logic                serial_en,
    output logic [7:0]          icr_o,
    output logic [7:0]          status_o
);
    logic [7:0] icr_q;
    logic       ps_armed_q;
    logic       wr_ok;
    logic       per_evt, ps_evt, alm_evt;
    logic       wd_fire, wd_rst;
    logic       irq_set;
    logic       pdown;

    assign pdown   = icr_q[C_PDOWN];
    assign wr_ok   = icr_we & ~pdown;
    assign ps_evt  = pwr_fail & icr_q[C_PSEN] & ps_armed_q;
    assign alm_evt = alarm_match & icr_q[C_ALEN];

    // control byte; an interrupt drops the power-down bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icr_q <= '0;
        end else begin
            if (wr_ok)   icr_q <= icr_wdata;
            if (irq_set) icr_q[C_PDOWN] <= 1'b0;
        end
    end

    // power-sense arms on a 0-to-1 write, disarms on event or 0 write
    always_ff @(posedge clk) begin
        if (!rst_n)                       ps_armed_q <= 1'b0;
        else if (wr_ok && !icr_wdata[C_PSEN]) ps_armed_q <= 1'b0;
        else if (wr_ok && !icr_q[C_PSEN]) ps_armed_q <= 1'b1;
        else if (ps_evt)                  ps_armed_q <= 1'b0;
    end

    rtc_periodic_sel #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_per (
        .clk(clk), .rst_n(rst_n), .sel(icr_q[SEL_W-1:0]), .taps(taps),
        .min_carry(min_carry), .hour_carry(hour_carry), .day_carry(day_carry),
        .evt(per_evt)
    );

    rtc_wdog #(.WD_LIMIT(WD_LIMIT), .CPUR_PULSE(CPUR_PULSE)) u_wd (
        .clk(clk), .rst_n(rst_n), .en(icr_q[C_WDOG]), .ce(ce),
        .ce_xfer(ce_xfer), .wd_tick(wd_tick), .fire(wd_fire), .rst_active(wd_rst)
    );

    rtc_irq_status u_st (
        .clk(clk), .rst_n(rst_n), .alm_evt(alm_evt), .osc_tick(osc_tick),
        .ps_evt(ps_evt), .per_evt(per_evt), .wd_fire(wd_fire),
        .ps_clr(wr_ok & ~icr_wdata[C_PSEN]), .stat_rd(stat_rd),
        .status(status_o), .irq_set(irq_set)
    );

    assign int_n     = ~status_o[S_IRQ];
    assign pse       = ~pdown;
    assign clkout_en = ~pdown;
    assign serial_en = ~pdown;
    assign cpur_n    = ~pdown & ~wd_rst;
    assign icr_o     = icr_q;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
// Checker: cycle-level properties of the controller, bound to the top.
module rtc_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       icr_we,
    input logic [7:0] icr_wdata,
    input logic       stat_rd,
    input logic       int_n,
    input logic       cpur_n,
    input logic       pse,
    input logic       clkout_en,
    input logic       serial_en,
    input logic [7:0] icr_o,
    input logic [7:0] status_o
);
    // R4: interrupt line stays low until a status read
    assert_int_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !stat_rd) |=> !int_n);

    // R2: a read keeps the power-sense flag unless sensing is written off
    assert_ps_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && status_o[2] && !(icr_we && serial_en && !icr_wdata[5])) |=> status_o[2]);

    // R11: first-time-up never returns after a read
    assert_ftu_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !status_o[4]);

    // R7: a watchdog fire comes with CPU reset low
    assert_wd_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[6]) |-> !cpur_n);

    // R9: power-down write drives the outputs low next cycle
    assert_pd_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_we && serial_en && icr_wdata[6]) |=> (!pse && !clkout_en && !cpur_n));

    // R9: writes while the serial path is off leave the other control bits
    assert_pd_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_we && !serial_en) |=> ({icr_o[7], icr_o[5:0]} == $past({icr_o[7], icr_o[5:0]})));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .icr_we(icr_we), .icr_wdata(icr_wdata),
    .stat_rd(stat_rd), .int_n(int_n), .cpur_n(cpur_n), .pse(pse),
    .clkout_en(clkout_en), .serial_en(serial_en), .icr_o(icr_o),
    .status_o(status_o)
);

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        icr_we = 1'b0;
    logic [7:0]  icr_wdata = '0;
    logic        stat_rd = 1'b0;
    logic        alarm_match = 1'b0;
    logic        osc_tick = 1'b0;
    logic        pwr_fail = 1'b0;
    logic [11:0] taps = '0;
    logic        min_carry = 1'b0, hour_carry = 1'b0, day_carry = 1'b0;
    logic        ce = 1'b0, ce_xfer = 1'b0, wd_tick = 1'b0;
    logic        int_n, cpur_n, pse, clkout_en, serial_en;
    logic [7:0]  icr_o, status_o;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    rtc_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .icr_we(icr_we), .icr_wdata(icr_wdata),
        .stat_rd(stat_rd), .alarm_match(alarm_match), .osc_tick(osc_tick),
        .pwr_fail(pwr_fail), .taps(taps), .min_carry(min_carry),
        .hour_carry(hour_carry), .day_carry(day_carry), .ce(ce),
        .ce_xfer(ce_xfer), .wd_tick(wd_tick), .int_n(int_n), .cpur_n(cpur_n),
        .pse(pse), .clkout_en(clkout_en), .serial_en(serial_en),
        .icr_o(icr_o), .status_o(status_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); icr_we = 1'b1; icr_wdata = d;
        @(negedge clk); icr_we = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // source s: 0..11 tap rising edge, 12 minute, 13 hour, 14 day
    task automatic src_pulse(input int s);
        @(negedge clk);
        if (s < 12) taps[s] = 1'b1;
        else if (s == 12) min_carry = 1'b1;
        else if (s == 13) hour_carry = 1'b1;
        else day_carry = 1'b1;
        @(negedge clk);
        taps = '0; min_carry = 1'b0; hour_carry = 1'b0; day_carry = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); wd_tick = 1'b1;
        @(negedge clk); wd_tick = 1'b0;
    endtask

    task automatic ce_cycle(input logic with_xfer);
        @(negedge clk); ce = 1'b1; ce_xfer = with_xfer;
        @(negedge clk); ce = 1'b0;
        @(negedge clk); ce_xfer = 1'b0;
    endtask

    task automatic outs(input string req, input logic exp);
        chk(req, {4'd0, pse, clkout_en, serial_en, cpur_n}, exp ? 8'h0F : 8'h00);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 icr", icr_o, 8'h00);
        chk("R1 status", status_o, 8'h10);
        chk("R1 int_n", {7'd0, int_n}, 8'h01);
        outs("R1 outputs", 1'b1);
        rd();
        chk("R11 ftu cleared by read", status_o, 8'h00);

        // R3 / R4 sweep: every code against every source
        for (int code = 0; code < 16; code++) begin
            wr(8'(code));
            rd();
            for (int s = 0; s < 15; s++) begin
                logic hit;
                hit = (code != 0) && (s == code - 1);
                src_pulse(s);
                chk("R3 periodic flag", status_o, hit ? 8'h09 : 8'h00);
                chk("R4 int_n", {7'd0, int_n}, hit ? 8'h00 : 8'h01);
                if (hit) begin
                    rd();
                    chk("R4 int released by read", {7'd0, int_n}, 8'h01);
                end
            end
        end

        // R5 alarm waits for the oscillator tick
        wr(8'h10); rd();
        @(negedge clk); alarm_match = 1'b1;
        @(negedge clk); alarm_match = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 alarm before tick", status_o, 8'h00);
        @(negedge clk); osc_tick = 1'b1;
        @(negedge clk); osc_tick = 1'b0;
        chk("R5 alarm after tick", status_o, 8'h0A);
        rd();
        wr(8'h00);
        @(negedge clk); alarm_match = 1'b1;
        @(negedge clk); alarm_match = 1'b0; osc_tick = 1'b1;
        @(negedge clk); osc_tick = 1'b0;
        chk("R5 alarm disabled", status_o, 8'h00);

        // R6 power sense and re-arm
        wr(8'h20);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
        chk("R6 power-sense set", status_o, 8'h0C);
        rd();
        chk("R2 read keeps power-sense", status_o, 8'h04);
        chk("R4 int high after read", {7'd0, int_n}, 8'h01);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
        chk("R6 disarmed ignores fail", status_o, 8'h04);
        wr(8'h00);
        chk("R6 write 0 clears flag", status_o, 8'h00);
        wr(8'h20);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
        chk("R6 re-armed", status_o, 8'h0C);
        wr(8'h00); rd();

        // R2 read in the same cycle as a new event
        wr(8'h0D); rd();
        @(negedge clk); stat_rd = 1'b1; min_carry = 1'b1;
        @(negedge clk); stat_rd = 1'b0; min_carry = 1'b0;
        chk("R2 collision keeps new flag", status_o, 8'h09);
        wr(8'h00); rd();

        // R7 / R8 watchdog
        wr(8'h80); rd();
        tick();
        chk("R7 one tick no fire", status_o, 8'h00);
        tick();
        chk("R7 fire flag", status_o, 8'h40);
        chk("R7 cpur low", {7'd0, cpur_n}, 8'h00);
        repeat (4) @(negedge clk);
        chk("R7 cpur pulse ends", {7'd0, cpur_n}, 8'h01);
        rd();
        tick();
        ce_cycle(1'b0);
        tick();
        chk("R7 serviced no fire", status_o, 8'h00);
        chk("R7 cpur high", {7'd0, cpur_n}, 8'h01);
        ce_cycle(1'b1);
        tick();
        chk("R8 transfer cycle does not service", status_o, 8'h40);
        wr(8'h00);
        repeat (5) @(negedge clk);
        rd();

        // R9 / R10 power-down
        wr(8'h4C);
        outs("R9 outputs low", 1'b0);
        chk("R9 icr", icr_o, 8'h4C);
        wr(8'h00);
        chk("R9 write ignored", icr_o, 8'h4C);
        src_pulse(11);
        outs("R10 outputs restored", 1'b1);
        chk("R10 power-down bit cleared", icr_o, 8'h0C);
        chk("R10 flag", status_o, 8'h09);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule